// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions with an external Ethernet PHY over a two-wire management link: a management clock (MDC) and a shared bidirectional data line (MDIO). The host gives a one-cycle start strobe together with a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then serialises one complete clause-22 style frame. A write finishes with the data shifted out. A read finishes with the 16-bit value the PHY returned. In both cases a one-cycle done pulse closes the transaction.

MDC is produced only while a transaction is in flight. Its low and high phases are each a parameterised number of system clocks. The data line is driven through a separate output enable, so the pad can tri-state it. On a read the block releases the line for the turnaround. It then checks that the PHY pulls the second turnaround bit low. If the PHY does not, the block stops the frame right there and raises an error flag, and the previously captured read data is kept.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc, mdio_oe, busy, done and error are 0 and rd_data is 0x0000.
- R2: A write (rd_nwr=0) emits 64 bits, each sampled at an MDC rising edge. The order is: 32 ones; start bits 0,1; opcode 0,1; the PHY address MSB first; the register address MSB first; turnaround 1,0; the 16 data bits MSB first. mdio_oe is 1 for all 64 bits.
- R3: A read (rd_nwr=1) drives 46 bits with mdio_oe=1. The order is: 32 ones; start bits 0,1; opcode 1,0; the PHY address MSB first; the register address MSB first. mdio_oe is 0 from the 47th bit (first turnaround bit) to the end of the frame.
- R4: On a read whose 48th bit (second turnaround) is sampled 0, the next 16 bits are sampled on mdio_i at MDC rising edges, MSB first. They appear on rd_data when done pulses, with error=0. The frame has 64 MDC cycles.
- R5: On a read whose 48th bit is sampled 1, the frame ends after 48 MDC cycles. done pulses with error=1, and rd_data keeps its previous value.
- R6: During a transaction each MDC low phase lasts MDC_LOW_CLKS system clocks and each high phase MDC_HIGH_CLKS clocks. Each frame starts with a low phase.
- R7: mdio_o and mdio_oe change only in cycles where mdc is low, so they are stable across every MDC rising edge.
- R8: busy rises in the cycle after an accepted start and falls in the cycle done pulses. A start while busy is 1 is ignored: the frame in progress is unchanged and only one done follows.
- R9: While busy is 0, mdio_oe and mdc are 0.
- R10: done is a single-cycle pulse. error keeps its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| rd_nwr | input | 1 | 1 = read, 0 = write; sampled with start |
| phy_addr | input | 5 | Target PHY address; sampled with start |
| reg_addr | input | 5 | Target register address; sampled with start |
| wr_data | input | 16 | Value to write; sampled with start |
| rd_data | output | 16 | Last successfully read value |
| done | output | 1 | One-cycle end-of-transaction pulse |
| error | output | 1 | Last read aborted on a bad turnaround |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | Data sampled from MDIO |

## Verification
The hardest case to reach is the aborted read. The PHY must present a high level at exactly the second turnaround bit and not at any other, and then the bench must show that the earlier read value survives. The bench acts as a PHY that counts MDC rising edges. It places each response bit on mdio_i just after the preceding rising edge. A per-test flag chooses what the turnaround bit returns. The bench runs a good read first, so that rd_data holds a known value before the faulty read starts. The ignored start is forced by strobing a read request with different addresses in the middle of a write, and then comparing the whole captured frame with the write that was accepted.

// File: rtl/mdio_pkg.sv
// Package: shared frame geometry and field types for the MDIO master.
// Assumes clause-22 framing: 32-bit preamble, 64 bit slots per frame.
package mdio_pkg;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA1_IDX    = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int TA2_IDX    = TA1_IDX + 1;
    localparam int LAST_IDX   = FRAME_BITS - 1;

    typedef logic [ADDR_W-1:0] mdio_addr_t;
    typedef logic [DATA_W-1:0] mdio_data_t;
    typedef logic [FRAME_BITS-1:0] mdio_frame_t;
    typedef logic [IDX_W-1:0] mdio_idx_t;
endpackage

// File: rtl/mdio_clkdiv.sv
// Module: MDC generator. It counts system clocks to form the low and high
// phases while run is 1, and holds MDC low with the counter cleared
// otherwise. rise_o/fall_o flag the cycle whose clock edge flips MDC.
// Assumes both phase lengths are at least one clock.
module mdio_clkdiv #(
    parameter int LOW_CLKS  = 100,
    parameter int HIGH_CLKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_o,
    output logic fall_o
);
    localparam int MAXC  = (LOW_CLKS > HIGH_CLKS) ? LOW_CLKS : HIGH_CLKS;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    logic [CNT_W-1:0] cnt;
    logic             lo_end;
    logic             hi_end;

    assign lo_end = !mdc && (cnt == CNT_W'(LOW_CLKS - 1));
    assign hi_end =  mdc && (cnt == CNT_W'(HIGH_CLKS - 1));
    assign rise_o = run && lo_end;
    assign fall_o = run && hi_end;

    // Phase counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc <= 1'b0;
            cnt <= '0;
        end else if (!run) begin
            mdc <= 1'b0;
            cnt <= '0;
        end else if (lo_end || hi_end) begin
            mdc <= ~mdc;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_seq.sv
// Module: frame sequencer. It loads the whole outgoing frame into a shift
// register on an accepted start and advances one bit per MDC falling
// edge. On reads it samples the line at MDC rising edges, checks the
// second turnaround bit and collects the 16 data bits.
// Assumes rise/fall strobes come from mdio_clkdiv and never coincide.
module mdio_seq
    import mdio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd_nwr,
    input  mdio_addr_t phy_addr,
    input  mdio_addr_t reg_addr,
    input  mdio_data_t wr_data,
    input  logic       mdio_i,
    input  logic       rise,
    input  logic       fall,
    output logic       busy,
    output logic       mdio_o,
    output logic       mdio_oe,
    output mdio_data_t rd_data,
    output logic       done,
    output logic       error
);
    mdio_frame_t shreg;
    mdio_idx_t   bit_idx;
    mdio_data_t  rx_sh;
    logic        is_rd;
    logic        ta_bad;
    logic        at_last;
    logic        abort;

    assign at_last = (bit_idx == mdio_idx_t'(LAST_IDX));
    assign abort   = is_rd && ta_bad && (bit_idx == mdio_idx_t'(TA2_IDX));
    assign mdio_o  = mdio_oe && shreg[FRAME_BITS-1];

    // Accept requests, shift frame bits out and finish transactions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            is_rd   <= 1'b0;
            shreg   <= '0;
            bit_idx <= '0;
            mdio_oe <= 1'b0;
            ta_bad  <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    is_rd   <= rd_nwr;
                    bit_idx <= '0;
                    mdio_oe <= 1'b1;
                    ta_bad  <= 1'b0;
                    error   <= 1'b0;
                    if (rd_nwr)
                        shreg <= {{PRE_BITS{1'b1}}, 2'b01, 2'b10, phy_addr,
                                  reg_addr, {(2 + DATA_W){1'b0}}};
                    else
                        shreg <= {{PRE_BITS{1'b1}}, 2'b01, 2'b01, phy_addr,
                                  reg_addr, 2'b10, wr_data};
                end
            end else begin
                if (rise && is_rd && (bit_idx == mdio_idx_t'(TA2_IDX)))
                    ta_bad <= mdio_i;
                if (fall) begin
                    if (at_last || abort) begin
                        busy    <= 1'b0;
                        mdio_oe <= 1'b0;
                        done    <= 1'b1;
                        error   <= abort;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                        if (is_rd && (bit_idx == mdio_idx_t'(TA1_IDX - 1)))
                            mdio_oe <= 1'b0;
                    end
                end
            end
        end
    end

    // Collect read data bits after the turnaround, publish on success.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rd_data <= '0;
        end else begin
            if (busy && rise && is_rd && (bit_idx > mdio_idx_t'(TA2_IDX)))
                rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
            if (busy && fall && at_last && is_rd)
                rd_data <= rx_sh;
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: top of the MDIO management frame master. It joins the MDC
// generator and the frame sequencer. MDC runs only while busy.
// Assumes MDC_LOW_CLKS and MDC_HIGH_CLKS are both at least 1.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int MDC_LOW_CLKS  = 100,
    parameter int MDC_HIGH_CLKS = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        done,
    output logic        error,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic rise;
    logic fall;

    mdio_clkdiv #(
        .LOW_CLKS (MDC_LOW_CLKS),
        .HIGH_CLKS(MDC_HIGH_CLKS)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .mdc   (mdc),
        .rise_o(rise),
        .fall_o(fall)
    );

    mdio_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rd_nwr  (rd_nwr),
        .phy_addr(phy_addr),
        .reg_addr(reg_addr),
        .wr_data (wr_data),
        .mdio_i  (mdio_i),
        .rise    (rise),
        .fall    (fall),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_data (rd_data),
        .done    (done),
        .error   (error)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: port-level checker for mdio_master, attached by bind.
module mdio_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic error,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc)); // R9
    AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> done); // R5
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(error)); // R10
    AST_FIRST_PHASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mdc); // R6
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .error  (error),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
);

// File: tb/sim_mdio_master.sv
// Bench: directed tests for mdio_master with a behavioural PHY model.
module sim_mdio_master;
    localparam int LOWC  = 2;
    localparam int HIGHC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        done, error, busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_master #(.MDC_LOW_CLKS(LOWC), .MDC_HIGH_CLKS(HIGHC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .error(error), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // Monitor and PHY model state.
    int          k = 0;
    logic [63:0] cap_o, cap_oe;
    logic        prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
    int          lo_len = 0, hi_len = 0, phase_bad = 0, r7_bad = 0;
    int          idle_bad = 0, done_cnt = 0, done_run = 0, done_long = 0;
    logic        phy_rd = 1'b0, phy_ta2 = 1'b0;
    logic [15:0] phy_word = '0;

    function automatic logic phy_bit(int j);
        if (!phy_rd) return 1'b1;
        if (j == 47) return phy_ta2;
        if (j >= 48 && j <= 63) return phy_word[63 - j];
        return 1'b1;
    endfunction

    // Observe outputs between clock edges and play the PHY side.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (start && !busy) begin
                k = 0; cap_o = '0; cap_oe = '0; mdio_i = 1'b1;
            end
            if (mdc && !prev_mdc) begin
                if (lo_len != LOWC) phase_bad++;
                lo_len = 0;
                if (k < 64) begin
                    cap_o[63 - k]  = mdio_o;
                    cap_oe[63 - k] = mdio_oe;
                end
                k++;
                mdio_i = phy_bit(k);
            end
            if (!mdc && prev_mdc) begin
                if (hi_len != HIGHC) phase_bad++;
                hi_len = 0;
            end
            if (mdc) hi_len++;
            else if (busy) lo_len++;
            if (((mdio_o != prev_o) || (mdio_oe != prev_oe)) && mdc) r7_bad++;
            if (!busy && (mdio_oe || mdc)) idle_bad++;
            if (done) begin done_cnt++; done_run++; end
            else done_run = 0;
            if (done_run > 1) done_long++;
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
        if (cyc == 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic kick(logic rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
        @(negedge clk);
        rd_nwr = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 mdc", 64'(mdc), 0);
        chk("R1 oe", 64'(mdio_oe), 0);
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 error", 64'(error), 0);
        chk("R1 rd_data", 64'(rd_data), 0);
    endtask

    task automatic t_write(logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
        int d0 = done_cnt;
        phy_rd = 1'b0;
        kick(1'b0, pa, ra, wd);
        chk("R8 busy after start", 64'(busy), 1);
        wait_done();
        chk("R2 write frame", cap_o, {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd});
        chk("R2 write oe", cap_oe, '1);
        chk("R2 write bit count", 64'(k), 64);
        chk("R10 error clear on write", 64'(error), 0);
        chk("R8 one done", 64'(done_cnt - d0), 1);
        chk("R8 busy low after done", 64'(busy), 0);
    endtask

    task automatic t_read(logic [4:0] pa, logic [4:0] ra, logic [15:0] pw);
        logic [63:0] m;
        m = {{46{1'b1}}, 18'b0};
        phy_rd = 1'b1; phy_ta2 = 1'b0; phy_word = pw;
        kick(1'b1, pa, ra, 16'h0);
        wait_done();
        chk("R3 read header", cap_o & m, {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 18'b0});
        chk("R3 read oe", cap_oe, m);
        chk("R4 read data", 64'(rd_data), 64'(pw));
        chk("R4 read error", 64'(error), 0);
        chk("R4 read bit count", 64'(k), 64);
    endtask

    task automatic t_read_bad(logic [15:0] keep);
        phy_rd = 1'b1; phy_ta2 = 1'b1; phy_word = 16'h5A5A;
        kick(1'b1, 5'h03, 5'h02, 16'h0);
        wait_done();
        chk("R5 abort bit count", 64'(k), 48);
        chk("R5 abort error", 64'(error), 1);
        chk("R5 rd_data kept", 64'(rd_data), 64'(keep));
        repeat (30) @(negedge clk);
        chk("R10 error held", 64'(error), 1);
        chk("R9 idle busy", 64'(busy), 0);
    endtask

    task automatic t_start_busy();
        int d0 = done_cnt;
        phy_rd = 1'b0;
        kick(1'b0, 5'h0A, 5'h15, 16'h8001);
        repeat (100) @(negedge clk);
        rd_nwr = 1'b1; phy_addr = 5'h1F; reg_addr = 5'h1F; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R8 frame unchanged", cap_o, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h8001});
        repeat (40) @(negedge clk);
        chk("R8 single done", 64'(done_cnt - d0), 1);
        chk("R8 no restart", 64'(busy), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_write(5'h11, 5'h00, 16'h8000);
        t_write(5'h0E, 5'h1B, 16'h3C96);
        t_read(5'h01, 5'h02, 16'hA5C3);
        t_read(5'h1F, 5'h05, 16'hFFFF);
        t_read_bad(16'hFFFF);
        t_write(5'h00, 5'h04, 16'h0001);
        t_start_busy();
        chk("R6 phase lengths", 64'(phase_bad), 0);
        chk("R7 change only while low", 64'(r7_bad), 0);
        chk("R9 idle quiet", 64'(idle_bad), 0);
        chk("R10 done width", 64'(done_long), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule